// File: doc/BRIEF.md
# MMC Command Line Sequencer

This block owns the command line of an SD/MMC host controller. Software or a higher-level controller hands it a command descriptor through a single write strobe. The descriptor carries a command index, a response kind and a special-command code, and a 32-bit argument travels alongside it. The block turns the descriptor into a 48-bit frame protected by a CRC7. It shifts that frame out one bit per card clock enable. It then listens for the card's reply of the selected length. A ready flag tells the requester when the next descriptor may be written.

Beyond plain commands, the sequencer handles three special cases. The first is the power-up clock burst, in which the line is held high for a fixed number of card clocks. The second is a command held back until the data path reports the end of its current block. The third is an interrupt-mode lock: once entered, it admits only an interrupt response. For busy-signalling responses, the block keeps ready low until the data-0 line is released. While a command is in flight, writes to the descriptor port have no effect.

Top module: `mmc_cmd_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `cmd_rdy` is 1 and `cmd_out` is 1. `cmd_rdy` falls on the clock after an accepted write. It rises on the clock edge that consumes the last tick of the active command.
- R2: A transmitted frame is, first to last: a 0, a 1, the 6-bit index MSB first, the 32-bit argument MSB first, the CRC7 (polynomial x^7+x^3+1, zero seed) over those 40 bits, and a closing 1. Each bit stays on `cmd_out` until a clock edge with `clk_en` high consumes it. For index 0 and argument 0, the frame is 48'h400000000095.
- R3: The descriptor `wr_cmd` holds the index in bits [5:0], the response kind in bits [7:6] and the special code in bits [10:8]. Response kind 0 means none, 1 means 48 bits, 2 means 136 bits and 3 means 48 bits followed by busy. Special code 0 means standard, 1 init burst, 2 wait-for-block-end, 4 interrupt command and 5 interrupt response. Codes 3, 6 and 7 act as standard.
- R4: A write strobe while `cmd_rdy` is 0 is dropped and does not disturb the command in progress.
- R5: The init code sends no frame. It holds `cmd_out` at 1 for 74 ticks, takes no response, and then returns to ready.
- R6: The wait-for-block-end code keeps `cmd_out` at 1 and `cmd_rdy` at 0 until `blk_end` is seen high on a clock edge. The frame starts on the next clock.
- R7: An accepted interrupt command sets `it_lock`. While `it_lock` is 1, every write whose special code is not 5 is dropped. An accepted interrupt response clears `it_lock`.
- R8: After the frame, the block waits for a 0 on `cmd_in`, sampled on ticks. If 64 ticks pass with the line high, `rsp_timeout` is set and the block returns to ready. A start bit arriving on the 64th tick is still accepted.
- R9: Response bits, start bit included, are shifted into `rsp_bits` at bit 0, one per tick. Collection stops after 48 bits (kinds 1 and 3) or 136 bits (kind 2).
- R10: For 48-bit responses, `rsp_crc_err` is set when bits [7:1] of the response differ from the CRC7 of its first 40 bits. 136-bit responses never set it.
- R11: For kind 3, `cmd_rdy` stays 0 after the response until a tick finds `dat0_in` at 1.
- R12: An accepted write clears `rsp_timeout`, `rsp_crc_err` and `rsp_bits`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Card clock enable; one line bit per high cycle |
| wr_en | input | 1 | Descriptor write strobe |
| wr_cmd | input | 11 | Descriptor: index, response kind, special code |
| wr_arg | input | 32 | Command argument |
| blk_end | input | 1 | End-of-data-block pulse from the data path |
| cmd_in | input | 1 | Command line as driven by the card |
| dat0_in | input | 1 | Data-0 line, low while the card is busy |
| cmd_out | output | 1 | Command line driven by the host, idles high |
| cmd_rdy | output | 1 | Ready for a new descriptor |
| it_lock | output | 1 | Interrupt-mode lock active |
| rsp_timeout | output | 1 | No response start bit within the window |
| rsp_crc_err | output | 1 | Response CRC7 mismatch |
| rsp_bits | output | 136 | Received response bits, latest at bit 0 |

## Verification
The bench builds the block with its default parameters: a 6-bit index, a 32-bit argument, 48- and 136-bit responses, a 74-tick init burst and a 64-tick response window. These are small enough that a full init burst and a full timeout window run in a few hundred clocks. Both edges of the response window are therefore hit: a start bit on the last admissible tick, and silence one tick longer. With the card clock enable at half rate, the bench also confirms that bits hold between ticks and that dropped writes fall in the gaps as well as on ticks.

// File: rtl/mmc_cmd_pkg.sv
package mmc_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_SYNC,
        ST_TX,
        ST_RWAIT,
        ST_RSP,
        ST_BUSY
    } seq_st_e;

    typedef enum logic [1:0] {
        RT_NONE  = 2'd0,
        RT_SHORT = 2'd1,
        RT_LONG  = 2'd2,
        RT_BUSY  = 2'd3
    } rsp_kind_e;

    localparam logic [2:0] SP_STD   = 3'd0;
    localparam logic [2:0] SP_INIT  = 3'd1;
    localparam logic [2:0] SP_SYNC  = 3'd2;
    localparam logic [2:0] SP_ITCMD = 3'd4;
    localparam logic [2:0] SP_ITRSP = 3'd5;

endpackage

// File: rtl/mmc_frame_build.sv
module mmc_frame_build #(
    parameter int IDX_W = 6,
    parameter int ARG_W = 32,
    localparam int MSG_W = IDX_W + ARG_W + 2,
    localparam int FRAME_W = MSG_W + 8
) (
    input  logic [IDX_W-1:0]   idx,
    input  logic [ARG_W-1:0]   arg,
    output logic [FRAME_W-1:0] frame
);

    logic [MSG_W-1:0] msg;
    logic [6:0]       crc;
    logic             fb;

    always_comb begin
        msg = {1'b0, 1'b1, idx, arg};
        crc = 7'd0;
        fb  = 1'b0;
        for (int i = MSG_W - 1; i >= 0; i--) begin
            fb     = msg[i] ^ crc[6];
            crc    = {crc[5:0], fb};
            crc[3] = crc[3] ^ fb;
        end
        frame = {msg, crc, 1'b1};
    end

endmodule

// File: rtl/mmc_crc7_ser.sv
module mmc_crc7_ser (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       din,
    output logic [6:0] crc
);

    logic [6:0] crc_d, crc_q;
    logic       fb;

    always_comb begin
        fb    = din ^ crc_q[6];
        crc_d = crc_q;
        if (clr) begin
            crc_d = 7'd0;
        end else if (en) begin
            crc_d = {crc_q[5:3], crc_q[2] ^ fb, crc_q[1:0], fb};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= 7'd0;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;

endmodule

// File: rtl/mmc_cmd_seq.sv
module mmc_cmd_seq
    import mmc_cmd_pkg::*;
#(
    parameter int IDX_W      = 6,
    parameter int ARG_W      = 32,
    parameter int SHORT_W    = 48,
    parameter int LONG_W     = 136,
    parameter int INIT_TICKS = 74,
    parameter int TMO_TICKS  = 64,
    localparam int CMD_W     = IDX_W + 5,
    localparam int FRAME_W   = IDX_W + ARG_W + 10,
    localparam int CRC_SPAN  = SHORT_W - 8,
    localparam int CNT_MAX_A = (FRAME_W > LONG_W) ? FRAME_W : LONG_W,
    localparam int CNT_MAX_B = (INIT_TICKS > TMO_TICKS) ? INIT_TICKS : TMO_TICKS,
    localparam int CNT_MAX   = (CNT_MAX_A > CNT_MAX_B) ? CNT_MAX_A : CNT_MAX_B,
    localparam int CNT_W     = $clog2(CNT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              wr_en,
    input  logic [CMD_W-1:0]  wr_cmd,
    input  logic [ARG_W-1:0]  wr_arg,
    input  logic              blk_end,
    input  logic              cmd_in,
    input  logic              dat0_in,
    output logic              cmd_out,
    output logic              cmd_rdy,
    output logic              it_lock,
    output logic              rsp_timeout,
    output logic              rsp_crc_err,
    output logic [LONG_W-1:0] rsp_bits
);

    typedef struct packed {
        seq_st_e             st;
        logic [CNT_W-1:0]    cnt;
        logic [FRAME_W-1:0]  sh;
        logic [LONG_W-1:0]   rsp;
        rsp_kind_e           rt;
        logic                rdy;
        logic                lock;
        logic                tmo;
        logic                crc_err;
    } seq_t;

    seq_t s_d, s_q;

    // descriptor fields
    logic [IDX_W-1:0]   idx_in;
    rsp_kind_e          rt_in;
    logic [2:0]         sp_in;
    logic [FRAME_W-1:0] frame;
    logic               accept;
    logic               crc_en;
    logic [6:0]         crc_rx;
    logic [LONG_W-1:0]  rsp_next;
    logic [CNT_W-1:0]   last_bit;

    assign idx_in = wr_cmd[IDX_W-1:0];
    assign rt_in  = rsp_kind_e'(wr_cmd[IDX_W+1:IDX_W]);
    assign sp_in  = wr_cmd[IDX_W+4:IDX_W+2];

    mmc_frame_build #(
        .IDX_W (IDX_W),
        .ARG_W (ARG_W)
    ) u_frame (
        .idx   (idx_in),
        .arg   (wr_arg),
        .frame (frame)
    );

    mmc_crc7_ser u_crc_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .en    (crc_en),
        .din   (cmd_in),
        .crc   (crc_rx)
    );

    always_comb begin
        s_d      = s_q;
        crc_en   = 1'b0;
        accept   = wr_en && s_q.rdy && (!s_q.lock || sp_in == SP_ITRSP);
        rsp_next = {s_q.rsp[LONG_W-2:0], cmd_in};
        last_bit = (s_q.rt == RT_LONG) ? CNT_W'(LONG_W - 1) : CNT_W'(SHORT_W - 1);

        unique case (s_q.st)
            ST_IDLE: begin
                if (accept) begin
                    s_d.tmo     = 1'b0;
                    s_d.crc_err = 1'b0;
                    s_d.rsp     = '0;
                    s_d.cnt     = '0;
                    s_d.rt      = rt_in;
                    s_d.sh      = frame;
                    if (sp_in == SP_ITCMD)      s_d.lock = 1'b1;
                    else if (sp_in == SP_ITRSP) s_d.lock = 1'b0;
                    if (sp_in == SP_INIT)       s_d.st = ST_INIT;
                    else if (sp_in == SP_SYNC)  s_d.st = ST_SYNC;
                    else                        s_d.st = ST_TX;
                end
            end
            ST_INIT: begin
                if (clk_en) begin
                    if (s_q.cnt == CNT_W'(INIT_TICKS - 1)) begin
                        s_d.cnt = '0;
                        s_d.st  = ST_IDLE;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            ST_SYNC: begin
                if (blk_end) s_d.st = ST_TX;
            end
            ST_TX: begin
                if (clk_en) begin
                    s_d.sh = {s_q.sh[FRAME_W-2:0], 1'b1};
                    if (s_q.cnt == CNT_W'(FRAME_W - 1)) begin
                        s_d.cnt = '0;
                        s_d.st  = (s_q.rt == RT_NONE) ? ST_IDLE : ST_RWAIT;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            ST_RWAIT: begin
                if (clk_en) begin
                    if (!cmd_in) begin
                        s_d.rsp = rsp_next;
                        crc_en  = 1'b1;
                        s_d.cnt = CNT_W'(1);
                        s_d.st  = ST_RSP;
                    end else if (s_q.cnt == CNT_W'(TMO_TICKS - 1)) begin
                        s_d.cnt = '0;
                        s_d.tmo = 1'b1;
                        s_d.st  = ST_IDLE;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            ST_RSP: begin
                if (clk_en) begin
                    s_d.rsp = rsp_next;
                    if (s_q.cnt < CNT_W'(CRC_SPAN)) crc_en = 1'b1;
                    if (s_q.cnt == last_bit) begin
                        s_d.cnt = '0;
                        if (s_q.rt != RT_LONG) s_d.crc_err = (rsp_next[7:1] != crc_rx);
                        s_d.st = (s_q.rt == RT_BUSY) ? ST_BUSY : ST_IDLE;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            ST_BUSY: begin
                if (clk_en && dat0_in) s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase

        s_d.rdy = (s_d.st == ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.st      <= ST_IDLE;
            s_q.rt      <= RT_NONE;
            s_q.sh      <= '1;
            s_q.rdy     <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_out     = (s_q.st == ST_TX) ? s_q.sh[FRAME_W-1] : 1'b1;
    assign cmd_rdy     = s_q.rdy;
    assign it_lock     = s_q.lock;
    assign rsp_timeout = s_q.tmo;
    assign rsp_crc_err = s_q.crc_err;
    assign rsp_bits    = s_q.rsp;

    // ready implies a released line
    assert_idle_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rdy |-> cmd_out);

    // a freshly started frame opens with its start bit
    assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cmd_rdy) && s_q.st == ST_TX) |-> !cmd_out);

    // the line bit holds between card clock ticks
    assert_bit_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_TX && !clk_en) |=> $stable(cmd_out));

    // a write while busy leaves the outgoing frame untouched
    assert_write_protect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_rdy && wr_en && s_q.st == ST_TX && !clk_en) |=> $stable(s_q.sh));

    // under the lock, non-response writes are dropped
    assert_lock_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (it_lock && cmd_rdy && wr_en && sp_in != SP_ITRSP) |=> (cmd_rdy && it_lock));

    // a timeout always hands control back
    assert_timeout_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_timeout) |-> cmd_rdy);

    // busy phase releases only on a tick with data-0 high
    assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_BUSY && !(clk_en && dat0_in)) |=> !cmd_rdy);

endmodule

// File: tb/sim_mmc_cmd_seq.sv
module sim_mmc_cmd_seq;

    localparam int LW = 136;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [10:0]   wr_cmd = '0;
    logic [31:0]   wr_arg = '0;
    logic          blk_end = 1'b0;
    logic          cmd_in = 1'b1;
    logic          dat0_in = 1'b1;
    logic          cmd_out, cmd_rdy, it_lock, rsp_timeout, rsp_crc_err;
    logic [LW-1:0] rsp_bits;

    mmc_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wr_en(wr_en),
        .wr_cmd(wr_cmd), .wr_arg(wr_arg), .blk_end(blk_end),
        .cmd_in(cmd_in), .dat0_in(dat0_in), .cmd_out(cmd_out),
        .cmd_rdy(cmd_rdy), .it_lock(it_lock), .rsp_timeout(rsp_timeout),
        .rsp_crc_err(rsp_crc_err), .rsp_bits(rsp_bits)
    );

    always #2 clk = ~clk;

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // behavioural reference: 0 idle 1 init 2 sync 3 tx 4 wait 5 rsp 6 busy
    int            mstate = 0;
    int            n = 0;
    int            rkind = 0;
    bit            txq[$];
    bit            m_lock = 0, m_tmo = 0, m_crc = 0;
    logic [LW-1:0] m_rsp = '0;
    logic [47:0]   line_log = '0;

    // card side
    bit card_q[$];
    int c_delay = 0;
    int busy_left = 0;

    function automatic logic [6:0] ref_crc(input logic [39:0] m);
        logic [46:0] r;
        r = {m, 7'd0};
        for (int i = 46; i >= 7; i--)
            if (r[i]) r[i-:8] = r[i-:8] ^ 8'h89;
        return r[6:0];
    endfunction

    task automatic check(input string req, input logic [LW-1:0] got, input logic [LW-1:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // reference model and card, stepped on every edge
    always @(posedge clk) begin
        if (!rst_n) begin
            mstate = 0; m_lock = 0; m_tmo = 0; m_crc = 0; m_rsp = '0;
            txq.delete();
        end else begin
            if (clk_en) begin
                if (mstate == 3) line_log = {line_log[46:0], cmd_out};
                if (mstate == 4 || mstate == 5) begin
                    if (c_delay > 0) c_delay--;
                    else if (card_q.size() > 0) void'(card_q.pop_front());
                end
                if (mstate == 6 && busy_left > 0) busy_left--;
            end
            case (mstate)
                0: if (wr_en && (!m_lock || wr_cmd[10:8] == 3'd5)) begin
                    logic [39:0] msg;
                    logic [47:0] fr;
                    m_tmo = 0; m_crc = 0; m_rsp = '0;
                    if (wr_cmd[10:8] == 3'd4) m_lock = 1;
                    if (wr_cmd[10:8] == 3'd5) m_lock = 0;
                    rkind = int'(wr_cmd[7:6]);
                    msg = {2'b01, wr_cmd[5:0], wr_arg};
                    fr = {msg, ref_crc(msg), 1'b1};
                    txq.delete();
                    for (int i = 47; i >= 0; i--) txq.push_back(fr[i]);
                    n = 0;
                    if (wr_cmd[10:8] == 3'd1)      mstate = 1;
                    else if (wr_cmd[10:8] == 3'd2) mstate = 2;
                    else                           mstate = 3;
                end
                1: if (clk_en) begin n++; if (n == 74) mstate = 0; end
                2: if (blk_end) mstate = 3;
                3: if (clk_en) begin
                    void'(txq.pop_front());
                    if (txq.size() == 0) begin n = 0; mstate = (rkind == 0) ? 0 : 4; end
                end
                4: if (clk_en) begin
                    if (cmd_in == 1'b0) begin
                        m_rsp = {m_rsp[LW-2:0], 1'b0}; n = 1; mstate = 5;
                    end else begin
                        n++;
                        if (n == 64) begin m_tmo = 1; mstate = 0; end
                    end
                end
                5: if (clk_en) begin
                    m_rsp = {m_rsp[LW-2:0], cmd_in};
                    n++;
                    if (n == ((rkind == 2) ? 136 : 48)) begin
                        if (rkind != 2) m_crc = (ref_crc(m_rsp[47:8]) != m_rsp[7:1]);
                        mstate = (rkind == 3) ? 6 : 0;
                    end
                end
                6: if (clk_en && dat0_in) mstate = 0;
                default: mstate = 0;
            endcase
        end
    end

    // compare, then drive the enable and the card lines
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            check({cur_req, " R2 cmd_out"}, LW'(cmd_out), LW'((mstate == 3) ? txq[0] : 1'b1));
            check({cur_req, " R1 cmd_rdy"}, LW'(cmd_rdy), LW'(mstate == 0));
            check({cur_req, " R7 it_lock"}, LW'(it_lock), LW'(m_lock));
            check({cur_req, " R8 timeout"}, LW'(rsp_timeout), LW'(m_tmo));
            check({cur_req, " R10 crc_err"}, LW'(rsp_crc_err), LW'(m_crc));
            check({cur_req, " R9 rsp_bits"}, rsp_bits, m_rsp);
        end
        clk_en  = ~clk_en;
        cmd_in  = (c_delay == 0 && card_q.size() > 0) ? card_q[0] : 1'b1;
        dat0_in = (busy_left == 0);
    end

    always @(negedge clk) begin
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    function automatic logic [10:0] desc(input logic [5:0] idx, input logic [1:0] rt, input logic [2:0] sp);
        return {sp, rt, idx};
    endfunction

    task automatic write_cmd(input logic [10:0] c, input logic [31:0] a);
        @(negedge clk);
        wr_en = 1'b1; wr_cmd = c; wr_arg = a;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_ready();
        for (int k = 0; k < 4000 && !cmd_rdy; k++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic card_short(input logic [5:0] idx, input logic [31:0] d, input bit bad, input int dly);
        logic [39:0] m;
        logic [47:0] f;
        logic [6:0]  c;
        m = {2'b00, idx, d};
        c = ref_crc(m) ^ {6'd0, bad};
        f = {m, c, 1'b1};
        card_q.delete();
        for (int i = 47; i >= 0; i--) card_q.push_back(f[i]);
        c_delay = dly;
    endtask

    task automatic card_long(input logic [126:0] p, input int dly);
        logic [135:0] f;
        f = {2'b00, 6'h3f, p, 1'b1};
        card_q.delete();
        for (int i = 135; i >= 0; i--) card_q.push_back(f[i]);
        c_delay = dly;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        cur_req = "R1";
        check("R1 reset ready", LW'(cmd_rdy), LW'(1));
        check("R1 reset line", LW'(cmd_out), LW'(1));
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 R3: known frame for index 0, argument 0
        cur_req = "R2";
        write_cmd(desc(6'd0, 2'd0, 3'd0), 32'h0);
        wait_ready();
        check("R2 frame cmd0", LW'(line_log), LW'(48'h400000000095));

        // R3 R9 R10: short response, good CRC
        cur_req = "R9";
        card_short(6'd17, 32'hCAFE_0123, 1'b0, 5);
        write_cmd(desc(6'd17, 2'd1, 3'd0), 32'h1234_5678);
        wait_ready();
        check("R10 good crc", LW'(rsp_crc_err), LW'(0));
        check("R3 short rsp length", rsp_bits[47:0], LW'({2'b00, 6'd17, 32'hCAFE_0123, ref_crc({2'b00, 6'd17, 32'hCAFE_0123}), 1'b1}));

        // R10: bad CRC
        cur_req = "R10";
        card_short(6'd13, 32'h0000_0900, 1'b1, 2);
        write_cmd(desc(6'd13, 2'd1, 3'd0), 32'h0001_0000);
        wait_ready();
        check("R10 bad crc flagged", LW'(rsp_crc_err), LW'(1));

        // R12: flags cleared by the next accepted write
        cur_req = "R12";
        write_cmd(desc(6'd7, 2'd0, 3'd3), 32'hFFFF_FFFF);
        @(negedge clk);
        check("R12 crc flag cleared", LW'(rsp_crc_err), LW'(0));
        wait_ready();

        // R9: long response, no CRC judgement
        cur_req = "R9";
        card_long({63'h5A5A_0F0F_1234_5678, 64'hDEAD_BEEF_0BAD_F00D}, 0);
        write_cmd(desc(6'd2, 2'd2, 3'd0), 32'h0);
        wait_ready();
        check("R9 long rsp tail", rsp_bits[64:1], LW'(64'hDEAD_BEEF_0BAD_F00D));
        check("R10 long no crc", LW'(rsp_crc_err), LW'(0));

        // R11: busy after response
        cur_req = "R11";
        card_short(6'd12, 32'h0000_0B00, 1'b0, 1);
        busy_left = 7;
        write_cmd(desc(6'd12, 2'd3, 3'd0), 32'h0);
        wait_ready();
        check("R11 busy released", LW'(busy_left), LW'(0));

        // R8: silence past the window
        cur_req = "R8";
        card_q.delete(); c_delay = 0;
        write_cmd(desc(6'd8, 2'd1, 3'd0), 32'h0000_01AA);
        wait_ready();
        check("R8 timeout set", LW'(rsp_timeout), LW'(1));

        // R8: start bit on the last admissible tick
        cur_req = "R8";
        card_short(6'd8, 32'h0000_01AA, 1'b0, 63);
        write_cmd(desc(6'd8, 2'd1, 3'd0), 32'h0000_01AA);
        wait_ready();
        check("R8 late start accepted", LW'(rsp_timeout), LW'(0));

        // R4: write in the middle of a frame
        cur_req = "R4";
        write_cmd(desc(6'd24, 2'd0, 3'd0), 32'h8000_0001);
        repeat (9) @(negedge clk);
        write_cmd(desc(6'd1, 2'd0, 3'd1), 32'h0);
        wait_ready();
        check("R4 frame intact", LW'(line_log), LW'({2'b01, 6'd24, 32'h8000_0001, ref_crc({2'b01, 6'd24, 32'h8000_0001}), 1'b1}));

        // R5: init burst
        cur_req = "R5";
        write_cmd(desc(6'd0, 2'd1, 3'd1), 32'h0);
        repeat (100) @(negedge clk);
        check("R5 line high in burst", LW'(cmd_out), LW'(1));
        check("R5 not ready in burst", LW'(cmd_rdy), LW'(0));
        wait_ready();

        // R6: held until block end
        cur_req = "R6";
        write_cmd(desc(6'd18, 2'd0, 3'd2), 32'h0000_0040);
        repeat (20) @(negedge clk);
        check("R6 held line", LW'(cmd_out), LW'(1));
        check("R6 held ready", LW'(cmd_rdy), LW'(0));
        blk_end = 1'b1;
        @(negedge clk);
        blk_end = 1'b0;
        check("R6 start bit after block end", LW'(cmd_out), LW'(0));
        wait_ready();

        // R7: interrupt lock
        cur_req = "R7";
        card_q.delete(); c_delay = 0;
        write_cmd(desc(6'd40, 2'd0, 3'd4), 32'h0);
        wait_ready();
        check("R7 lock set", LW'(it_lock), LW'(1));
        write_cmd(desc(6'd13, 2'd0, 3'd0), 32'h0);
        @(negedge clk);
        check("R7 std write dropped", LW'(cmd_rdy), LW'(1));
        check("R7 line quiet", LW'(cmd_out), LW'(1));
        write_cmd(desc(6'd40, 2'd0, 3'd5), 32'h0);
        wait_ready();
        check("R7 lock released", LW'(it_lock), LW'(0));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule